// File: doc/BRIEF.md
# CPU/PCI Ratio Clock Divider

This block turns one fast timebase (200 MHz in normal operation) into a CPU clock and a PCI clock whose rising edges stay aligned. A two-bit mode code selects the output behaviour. The high bit is the speed select and the low bit is the frequency select. Code 00 disables the outputs for a tristate board test. Code 01 gives a 66.6 MHz CPU clock, which is the timebase divided by 3. Code 11 gives a 100 MHz CPU clock, which is the timebase divided by 2. Code 10 is a test bypass, where the outputs are derived from an external test clock. In both active codes the PCI clock is the timebase divided by 6 (33.3 MHz). The CPU-to-PCI ratio is therefore 2 or 3.

One modulo-6 phase counter feeds every divided output. The CPU and PCI rising edges therefore fall in the same timebase cycle. A new mode code is taken only when that counter wraps, and the counter restarts at phase 0 in the new mode. In test mode the counter advances on each sampled rising edge of the test clock instead of on every timebase cycle. The reference output carries a sampled copy of the reference input in the active codes and a sampled copy of the test clock in test mode.

Every output is a register clocked by the timebase. The enable output tells the pad ring whether to drive the clock pins.

Top module: `cpupci_clkgen`

## Requirements
- R1: The reset input is asynchronous and active low. While it is low, every clock output and `oe_o` read 0. After reset, no output turns on until the synchronized release has passed.
- R2: With mode code 11, the CPU outputs repeat high,low every 2 timebase cycles. The PCI outputs repeat high,high,high,low,low,low every 6 cycles.
- R3: With mode code 01, the CPU outputs repeat high,low,low every 3 timebase cycles, a documented 33/67 duty cycle. The PCI outputs keep the same 6-cycle 50% pattern as in R2.
- R4: Every rising edge of the PCI outputs falls in the same timebase cycle as a rising edge of the CPU outputs.
- R5: With mode code 00, `oe_o` is 0 and the CPU, PCI, free-running PCI and reference outputs are all driven 0.
- R6: With mode code 10, the CPU outputs toggle on every sampled rising edge of `tclk_i` (test clock divided by 2). The PCI outputs run at the test clock divided by 6. `ref_o` follows `tclk_i`. `oe_o` is 1.
- R7: A change of the mode code takes effect only at the next counter wrap. The old pattern continues until then. The first cycle in the new mode is phase 0, where the CPU and PCI outputs are both high.
- R8: With an active mode code (01 or 11), `ref_o` equals `ref_i` as it was 3 timebase cycles earlier.
- R9: All CPU output bits are equal to each other, all PCI output bits are equal to each other, and `pcif_o` equals the PCI outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode code: bit 1 speed select, bit 0 frequency select |
| tclk_i | input | 1 | Test clock, used in mode 10 |
| ref_i | input | 1 | Reference (crystal) clock level |
| cpu_o | output | NCPU | CPU clock outputs |
| pci_o | output | NPCI | PCI clock outputs |
| pcif_o | output | 1 | Free-running PCI clock output |
| ref_o | output | 1 | Reference clock output |
| oe_o | output | 1 | Output enable, low in tristate mode |

## Verification
- **Wrong phase count or decode.** The fault shows as a CPU or PCI sample that differs from the expected pattern. It appears within one 6-cycle period after the first wrap that follows a check point.
- **Mode latched at the wrong time.** The switch from the old pattern to the new one lands in a cycle other than the one right after the wrap.
- **Broken test-clock edge detection.** The number of CPU, PCI and reference rising edges over a fixed window is wrong.
- **Stuck enable.** An enable stuck high shows at once in tristate mode, because the outputs must all read 0 there with the enable low.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    MODE_TRI  = 2'b00,
    MODE_SLOW = 2'b01,
    MODE_TEST = 2'b10,
    MODE_FAST = 2'b11
  } mode_e;
endpackage

// File: rtl/cg_rst_sync.sv
module cg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/cg_in_sample.sv
module cg_in_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_i,
  input  logic ref_i,
  output logic tclk_s_o,
  output logic tclk_rise_o,
  output logic ref_s_o
);
  logic [2:0] tclk_q;
  logic [1:0] ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tclk_q <= 3'b000;
      ref_q  <= 2'b00;
    end else begin
      tclk_q <= {tclk_q[1:0], tclk_i};
      ref_q  <= {ref_q[0], ref_i};
    end
  end

  assign tclk_s_o    = tclk_q[1];
  assign tclk_rise_o = tclk_q[1] & ~tclk_q[2];
  assign ref_s_o     = ref_q[1];
endmodule

// File: rtl/cg_phase_ctr.sv
module cg_phase_ctr
  import clkdiv_pkg::*;
#(
  parameter int PCI_DIV = 6,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          tclk_rise_i,
  output logic          tick_o,
  output logic [CW-1:0] cnt_nx_o,
  output mode_e         mode_nx_o
);
  localparam logic [CW-1:0] LAST = CW'(PCI_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  mode_e         mode_q, mode_d;
  logic          tick;

  always_comb begin
    tick   = (mode_q == MODE_TEST) ? tclk_rise_i : 1'b1;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (tick) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        mode_d = mode_e'(mode_i);
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      mode_q <= MODE_TRI;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign tick_o    = tick;
  assign cnt_nx_o  = cnt_d;
  assign mode_nx_o = mode_d;
endmodule

// File: rtl/cg_out_decode.sv
module cg_out_decode
  import clkdiv_pkg::*;
#(
  parameter int PCI_DIV  = 6,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 3,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_nx_i,
  input  mode_e         mode_nx_i,
  input  logic          ref_s_i,
  input  logic          tclk_s_i,
  output logic          cpu_o,
  output logic          pci_o,
  output logic          ref_o,
  output logic          oe_o
);
  localparam int FAST_HI = FAST_DIV / 2;
  localparam int SLOW_HI = SLOW_DIV / 2;
  localparam int PCI_HI  = PCI_DIV / 2;

  logic cpu_d, pci_d, ref_d, oe_d;
  logic cpu_q, pci_q, ref_q, oe_q;
  int   phase;

  always_comb begin
    phase = int'(cnt_nx_i);
    oe_d  = (mode_nx_i != MODE_TRI);
    pci_d = oe_d && (phase < PCI_HI);
    if (mode_nx_i == MODE_SLOW) cpu_d = (phase % SLOW_DIV) < SLOW_HI;
    else                        cpu_d = oe_d && ((phase % FAST_DIV) < FAST_HI);
    case (mode_nx_i)
      MODE_TRI:  ref_d = 1'b0;
      MODE_TEST: ref_d = tclk_s_i;
      default:   ref_d = ref_s_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q <= 1'b0;
      pci_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (tick_i) begin
      cpu_q <= cpu_d;
      pci_q <= pci_d;
      oe_q  <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign cpu_o = cpu_q;
  assign pci_o = pci_q;
  assign ref_o = ref_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/cpupci_clkgen.sv
module cpupci_clkgen
  import clkdiv_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int NPCI     = 5,
  parameter int PCI_DIV  = 6,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            tclk_i,
  input  logic            ref_i,
  output logic [NCPU-1:0] cpu_o,
  output logic [NPCI-1:0] pci_o,
  output logic            pcif_o,
  output logic            ref_o,
  output logic            oe_o
);
  localparam int CW = $clog2(PCI_DIV);

  logic          srst_n, tclk_s, tclk_rise, ref_s, tick;
  logic [CW-1:0] cnt_nx;
  mode_e         mode_nx;
  logic          cpu_b, pci_b;

  cg_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  cg_in_sample u_smp (
    .clk(clk), .rst_n(srst_n), .tclk_i(tclk_i), .ref_i(ref_i),
    .tclk_s_o(tclk_s), .tclk_rise_o(tclk_rise), .ref_s_o(ref_s)
  );

  cg_phase_ctr #(.PCI_DIV(PCI_DIV), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(srst_n), .mode_i(mode_i), .tclk_rise_i(tclk_rise),
    .tick_o(tick), .cnt_nx_o(cnt_nx), .mode_nx_o(mode_nx)
  );

  cg_out_decode #(
    .PCI_DIV(PCI_DIV), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .CW(CW)
  ) u_dec (
    .clk(clk), .rst_n(srst_n), .tick_i(tick), .cnt_nx_i(cnt_nx),
    .mode_nx_i(mode_nx), .ref_s_i(ref_s), .tclk_s_i(tclk_s),
    .cpu_o(cpu_b), .pci_o(pci_b), .ref_o(ref_o), .oe_o(oe_o)
  );

  assign cpu_o  = {NCPU{cpu_b}};
  assign pci_o  = {NPCI{pci_b}};
  assign pcif_o = pci_b;
endmodule

// File: rtl/cpupci_clkgen_chk.sv
module cpupci_clkgen_chk #(
  parameter int NCPU = 2,
  parameter int NPCI = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCPU-1:0] cpu_o,
  input logic [NPCI-1:0] pci_o,
  input logic            pcif_o,
  input logic            ref_o,
  input logic            oe_o
);
  assert_pci_rise_on_cpu_rise_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(pci_o[0]) |-> $rose(cpu_o[0]));

  assert_pci_high_two_cycles_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(pci_o[0]) |=> pci_o[0]);

  assert_quiet_when_disabled_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    !oe_o |-> (cpu_o == '0 && pci_o == '0 && !pcif_o && !ref_o));

  assert_copies_match_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cpu_o == {NCPU{cpu_o[0]}}) && (pci_o == {NPCI{pci_o[0]}}) && (pcif_o == pci_o[0]));
endmodule

bind cpupci_clkgen cpupci_clkgen_chk #(.NCPU(NCPU), .NPCI(NPCI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_o(cpu_o), .pci_o(pci_o),
  .pcif_o(pcif_o), .ref_o(ref_o), .oe_o(oe_o)
);

// File: tb/cpupci_clkgen_test.sv
`timescale 1ns/1ps
module cpupci_clkgen_test;
  localparam int NCPU = 2;
  localparam int NPCI = 5;

  // entry: {mode, cpu pattern phase0..5, pci pattern phase0..5, oe}
  localparam logic [14:0] VEC [5] = '{
    {2'b11, 6'b101010, 6'b111000, 1'b1},
    {2'b01, 6'b100100, 6'b111000, 1'b1},
    {2'b11, 6'b101010, 6'b111000, 1'b1},
    {2'b01, 6'b100100, 6'b111000, 1'b1},
    {2'b00, 6'b000000, 6'b000000, 1'b0}
  };

  logic clk, rst_n, tclk, refin, tclk_run;
  logic [1:0] mode;
  logic [NCPU-1:0] cpu;
  logic [NPCI-1:0] pci;
  logic pcif, refo, oe;
  int tests, fails;

  cpupci_clkgen #(.NCPU(NCPU), .NPCI(NPCI)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tclk_i(tclk), .ref_i(refin),
    .cpu_o(cpu), .pci_o(pci), .pcif_o(pcif), .ref_o(refo), .oe_o(oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    tclk = 1'b0;
    forever begin
      repeat (4) @(negedge clk);
      if (tclk_run) tclk = ~tclk;
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_pci_rise();
    logic prev;
    prev = pci[0];
    @(negedge clk);
    while (!(pci[0] && !prev)) begin
      prev = pci[0];
      @(negedge clk);
    end
  endtask

  function automatic logic all_eq(input logic [NCPU-1:0] c, input logic [NPCI-1:0] p, input logic f);
    return (c == {NCPU{c[0]}}) && (p == {NPCI{p[0]}}) && (f == p[0]);
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [14:0] prev_v;
    int cr, pr, rr;
    logic pc, pp, pf;
    tests = 0; fails = 0;
    rst_n = 1'b0; mode = 2'b11; refin = 1'b0; tclk_run = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {cpu[0], pci[0], refo, oe}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {cpu[0], pci[0], refo, oe}, 4'b0000);

    // vector table: R2 R3 R4 R5 R7 R9
    prev_v = VEC[0];
    foreach (VEC[i]) begin
      wait_pci_rise();
      mode = VEC[i][14:13];
      for (int k = 1; k <= 12; k++) begin
        logic [14:0] v;
        int ph;
        @(negedge clk);
        ph = k % 6;
        v = (k < 6) ? prev_v : VEC[i];
        check(v[14:13] == 2'b01 ? "R3/R7" : (v[0] ? "R2/R7" : "R5/R7"),
              {cpu[0], pci[0], oe, all_eq(cpu, pci, pcif)},
              {v[12-ph], v[6-ph], v[0], 1'b1});
      end
      prev_v = VEC[i];
    end
    check("R5", {refo, pcif, cpu[1], pci[4]}, 4'b0000);

    // R6: test mode from tristate
    tclk_run = 1'b1;
    mode = 2'b10;
    repeat (40) @(negedge clk);
    cr = 0; pr = 0; rr = 0;
    pc = cpu[0]; pp = pci[0]; pf = refo;
    for (int k = 0; k < 384; k++) begin
      @(negedge clk);
      if (cpu[0] && !pc) cr++;
      if (pci[0] && !pp) pr++;
      if (refo && !pf) rr++;
      pc = cpu[0]; pp = pci[0]; pf = refo;
    end
    check("R6 cpu", {3'b000, (cr >= 23 && cr <= 25)}, 4'b0001);
    check("R6 pci", {3'b000, (pr >= 7 && pr <= 9)}, 4'b0001);
    check("R6 ref", {3'b000, (rr >= 47 && rr <= 49)}, 4'b0001);
    check("R6 oe", {3'b000, oe}, 4'b0001);

    // leave test mode to 100 MHz: R7 phase 0 start, R2
    mode = 2'b11;
    repeat (80) @(negedge clk);
    tclk_run = 1'b0;
    wait_pci_rise();
    for (int k = 0; k < 6; k++) begin
      check("R2/R7", {cpu[0], pci[0], 2'b00},
            {(k % 2) == 0, k < 3, 2'b00});
      @(negedge clk);
    end

    // R8: reference follows with 3 cycle latency
    refin = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 early", {3'b000, refo}, 4'b0000);
    @(negedge clk);
    check("R8", {3'b000, refo}, 4'b0001);
    refin = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", {3'b000, refo}, 4'b0000);

    // R1: mid-run reset, then restart in 66.6 MHz mode
    mode = 2'b01;
    rst_n = 1'b0;
    #1;
    check("R1 async", {cpu[0], pci[0], refo, oe}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 release", {cpu[0], pci[0], refo, oe}, 4'b0000);
    repeat (6) @(negedge clk);
    check("R1 on", {3'b000, oe}, 4'b0001);
    wait_pci_rise();
    for (int k = 0; k < 6; k++) begin
      check("R3", {cpu[0], pci[0], 2'b00}, {(k % 3) == 0, k < 3, 2'b00});
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule